// File: doc/BRIEF.md
# FM Channel Stereo Mixer

This block forms one stereo output sample from the words of six FM synthesis channels. When the sample strobe is high, it reduces each channel word to a 9-bit signed quantity. It can then push that quantity away from zero by a fixed DC step, which models the crossover offset of the output converter. Each result is scaled by a ratio, and each channel is routed to the left sum, the right sum, or both according to its two pan bits. A registered left/right pair appears one cycle after the strobe, together with a one-cycle valid pulse.

The offset mode sits in a register that reset sets to "on". A channel whose side is muted adds no signal to that side. In offset mode it still adds the scaled DC step, with the sign of its own offset-adjusted sample. In plain mode it adds nothing.

Top module: `fm_stereo_mixer`

## Requirements
- R1: Only bits 13..5 of each 16-bit channel word take part. Bit 13 is the sign, and the word is read as the signed value {bit13, bit13, bits13..5, 00000}. Bits 15, 14 and 4..0 have no effect on the outputs.
- R2: In offset mode, a conditioned value that is zero or positive gets +112 added, and a negative value gets 112 subtracted. In plain mode no offset is applied.
- R3: Each enabled contribution is the adjusted value times 79 divided by 120 in offset mode, or times 2 divided by 3 in plain mode. The division truncates toward zero.
- R4: For channel i, pan bit 2i+1 enables the left side and pan bit 2i enables the right side.
- R5: A channel with a disabled side adds +73 to that side in offset mode when its adjusted value is zero or positive, and -73 when it is negative. In plain mode it adds 0.
- R6: After reset the offset mode is on. A cycle with the mode-write input high loads the mode-value input into the register. The new mode applies from the next clock edge on, so a strobe in the same cycle as the write still uses the old mode. The mode-value input alone has no effect.
- R7: An edge with the strobe high samples the inputs. The signed 18-bit left and right sums of all six contributions appear after that edge and hold until the next strobe. Full-scale inputs on every channel do not overflow.
- R8: Valid is high for exactly the one cycle after each strobe edge. During reset, valid and both sums are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ch_word_i | input | 96 | Six 16-bit channel words; channel i at bits 16i+15..16i |
| ch_pan_i | input | 12 | Pan pairs; bit 2i+1 left enable, bit 2i right enable for channel i |
| ofs_set_i | input | 1 | Load the offset-mode register this cycle |
| ofs_val_i | input | 1 | Value loaded into the offset-mode register (1 = offset mode) |
| smp_strobe_i | input | 1 | Sample the inputs and produce a sum pair |
| left_o | output | 18 | Signed left sum |
| right_o | output | 18 | Signed right sum |
| valid_o | output | 1 | One-cycle pulse marking a new sum pair |

## Verification
The mixer is driven with the following input patterns:
- All-zero words show the pure DC term of offset mode.
- Words whose ignored bits are set, and otherwise zero, separate correct masking from a full-width read.
- Full-scale positive and negative words on all six channels expose overflow and sign-extension errors.
- The word 0x3FE0 (value -32) checks that negative products truncate toward zero.
- Pan patterns with one side off, both sides off, and mixed per channel show the difference between muting a side and dropping its DC term.
- Mode writes, including one in the same cycle as a strobe and a mode value presented without a write, fix when a mode change takes effect.
- A long run of pseudo-random words and pans covers general mixes.

// File: rtl/fm_mix_pkg.sv
package fm_mix_pkg;

  typedef enum logic {
    MODE_PLAIN  = 1'b0,
    MODE_OFFSET = 1'b1
  } ofs_mode_e;

  // Scaled DC step for a muted side, truncated like the signal path.
  function automatic int muted_step(input int ofs, input int mul, input int div);
    return (ofs * mul) / div;
  endfunction

endpackage

// File: rtl/fm_mix_lane.sv
module fm_mix_lane
  import fm_mix_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int SIGN_BIT = 13,
  parameter int LSB_KEEP = 5,
  parameter int OFS      = 112,
  parameter int MUL_ON   = 79,
  parameter int DIV_ON   = 120,
  parameter int MUL_OFF  = 2,
  parameter int DIV_OFF  = 3,
  parameter int OUT_W    = 16
) (
  input  logic [WORD_W-1:0]       word_i,
  input  logic [1:0]              pan_i,
  input  ofs_mode_e               mode_i,
  output logic signed [OUT_W-1:0] left_o,
  output logic signed [OUT_W-1:0] right_o
);

  localparam int ADJ_W  = WORD_W + 1;
  localparam int PROD_W = ADJ_W + 16;
  localparam int MUTE   = muted_step(OFS, MUL_ON, DIV_ON);

  localparam logic signed [ADJ_W-1:0]  OFS_S     = ADJ_W'(OFS);
  localparam logic signed [PROD_W-1:0] MUL_ON_S  = PROD_W'(MUL_ON);
  localparam logic signed [PROD_W-1:0] DIV_ON_S  = PROD_W'(DIV_ON);
  localparam logic signed [PROD_W-1:0] MUL_OFF_S = PROD_W'(MUL_OFF);
  localparam logic signed [PROD_W-1:0] DIV_OFF_S = PROD_W'(DIV_OFF);
  localparam logic signed [OUT_W-1:0]  MUTE_P    = OUT_W'(MUTE);
  localparam logic signed [OUT_W-1:0]  MUTE_N    = -MUTE_P;

  logic signed [WORD_W-1:0] cond_s;
  logic signed [ADJ_W-1:0]  adj_s;
  logic signed [PROD_W-1:0] prod_s;
  logic signed [PROD_W-1:0] quo_s;
  logic signed [OUT_W-1:0]  scaled_s;
  logic signed [OUT_W-1:0]  mute_s;
  logic                     neg;

  // Keep the retained field and replicate its top bit upward.
  always_comb begin
    cond_s = '0;
    for (int b = LSB_KEEP; b <= SIGN_BIT; b++) cond_s[b] = word_i[b];
    for (int b = SIGN_BIT + 1; b < WORD_W; b++) cond_s[b] = word_i[SIGN_BIT];
  end

  assign neg = word_i[SIGN_BIT];

  // Push away from zero in offset mode; zero counts as positive.
  always_comb begin
    adj_s = ADJ_W'(cond_s);
    if (mode_i == MODE_OFFSET) begin
      adj_s = neg ? (ADJ_W'(cond_s) - OFS_S) : (ADJ_W'(cond_s) + OFS_S);
    end
  end

  // Signed divide truncates toward zero.
  always_comb begin
    if (mode_i == MODE_OFFSET) begin
      prod_s = PROD_W'(adj_s) * MUL_ON_S;
      quo_s  = prod_s / DIV_ON_S;
    end else begin
      prod_s = PROD_W'(adj_s) * MUL_OFF_S;
      quo_s  = prod_s / DIV_OFF_S;
    end
    scaled_s = quo_s[OUT_W-1:0];
  end

  always_comb begin
    mute_s = '0;
    if (mode_i == MODE_OFFSET) mute_s = neg ? MUTE_N : MUTE_P;
  end

  assign left_o  = pan_i[1] ? scaled_s : mute_s;
  assign right_o = pan_i[0] ? scaled_s : mute_s;

  logic unused_ok;
  assign unused_ok = ^{word_i[WORD_W-1:SIGN_BIT+1], word_i[LSB_KEEP-1:0],
                       quo_s[PROD_W-1:OUT_W]};

endmodule

// File: rtl/fm_mix_sum.sv
module fm_mix_sum #(
  parameter int N     = 6,
  parameter int IN_W  = 16,
  parameter int ACC_W = 18
) (
  input  logic [N*IN_W-1:0]       terms_i,
  output logic signed [ACC_W-1:0] sum_o
);

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < N; i++) begin
      sum_o = sum_o + ACC_W'($signed(terms_i[i*IN_W +: IN_W]));
    end
  end

endmodule

// File: rtl/fm_stereo_mixer.sv
module fm_stereo_mixer
  import fm_mix_pkg::*;
#(
  parameter int NUM_CH   = 6,
  parameter int WORD_W   = 16,
  parameter int SIGN_BIT = 13,
  parameter int LSB_KEEP = 5,
  parameter int OFS      = 112,
  parameter int MUL_ON   = 79,
  parameter int DIV_ON   = 120,
  parameter int MUL_OFF  = 2,
  parameter int DIV_OFF  = 3,
  parameter int TERM_W   = 16,
  parameter int ACC_W    = 18
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH*WORD_W-1:0] ch_word_i,
  input  logic [NUM_CH*2-1:0]      ch_pan_i,
  input  logic                     ofs_set_i,
  input  logic                     ofs_val_i,
  input  logic                     smp_strobe_i,
  output logic signed [ACC_W-1:0]  left_o,
  output logic signed [ACC_W-1:0]  right_o,
  output logic                     valid_o
);

  localparam int MUTE = muted_step(OFS, MUL_ON, DIV_ON);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // Offset mode register
  ofs_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (ofs_set_i) mode_d = ofs_mode_e'(ofs_val_i);
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) mode_q <= MODE_OFFSET;
    else            mode_q <= mode_d;
  end

  // Per-channel conditioning and scaling
  logic [NUM_CH*TERM_W-1:0] left_terms;
  logic [NUM_CH*TERM_W-1:0] right_terms;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    logic signed [TERM_W-1:0] l_t;
    logic signed [TERM_W-1:0] r_t;

    fm_mix_lane #(
      .WORD_W  (WORD_W),
      .SIGN_BIT(SIGN_BIT),
      .LSB_KEEP(LSB_KEEP),
      .OFS     (OFS),
      .MUL_ON  (MUL_ON),
      .DIV_ON  (DIV_ON),
      .MUL_OFF (MUL_OFF),
      .DIV_OFF (DIV_OFF),
      .OUT_W   (TERM_W)
    ) i_lane (
      .word_i (ch_word_i[g*WORD_W +: WORD_W]),
      .pan_i  (ch_pan_i[2*g +: 2]),
      .mode_i (mode_q),
      .left_o (l_t),
      .right_o(r_t)
    );

    assign left_terms[g*TERM_W +: TERM_W]  = l_t;
    assign right_terms[g*TERM_W +: TERM_W] = r_t;

    // R5: a muted side carries only the signed DC step, or nothing.
    assert_muted_left_R5: assert property (@(posedge clk_i) disable iff (!rst_n_int)
      !ch_pan_i[2*g+1] |->
        ((mode_q == MODE_OFFSET) ? (l_t == TERM_W'(MUTE) || l_t == -TERM_W'(MUTE))
                                 : (l_t == '0)));
    assert_muted_right_R5: assert property (@(posedge clk_i) disable iff (!rst_n_int)
      !ch_pan_i[2*g] |->
        ((mode_q == MODE_OFFSET) ? (r_t == TERM_W'(MUTE) || r_t == -TERM_W'(MUTE))
                                 : (r_t == '0)));
  end

  logic signed [ACC_W-1:0] left_sum, right_sum;

  fm_mix_sum #(.N(NUM_CH), .IN_W(TERM_W), .ACC_W(ACC_W)) i_sum_left (
    .terms_i(left_terms),
    .sum_o  (left_sum)
  );

  fm_mix_sum #(.N(NUM_CH), .IN_W(TERM_W), .ACC_W(ACC_W)) i_sum_right (
    .terms_i(right_terms),
    .sum_o  (right_sum)
  );

  // Output registers with explicit enable
  logic signed [ACC_W-1:0] left_d, right_d;
  logic                    valid_d;

  always_comb begin
    left_d  = left_o;
    right_d = right_o;
    valid_d = smp_strobe_i;
    if (smp_strobe_i) begin
      left_d  = left_sum;
      right_d = right_sum;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      left_o  <= left_d;
      right_o <= right_d;
      valid_o <= valid_d;
    end
  end

  // R8: one valid pulse per strobe, none otherwise.
  assert_valid_after_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    smp_strobe_i |=> valid_o);
  assert_valid_single_R8: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !smp_strobe_i |=> !valid_o);
  // R7: sums hold between strobes.
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !smp_strobe_i |=> ($stable(left_o) && $stable(right_o)));
  // R6: mode changes only through a write.
  assert_mode_write_R6: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !ofs_set_i |=> $stable(mode_q));

endmodule

// File: tb/test_fm_stereo_mixer.sv
module test_fm_stereo_mixer;

  logic        clk;
  logic        rst_n;
  logic [95:0] ch_word;
  logic [11:0] ch_pan;
  logic        ofs_set;
  logic        ofs_val;
  logic        strobe;
  logic signed [17:0] left_s, right_s;
  logic        valid;

  int checks = 0;
  int errors = 0;
  bit model_on = 1'b1;
  bit done = 1'b0;

  int    exp_l[$];
  int    exp_r[$];
  string exp_tag[$];

  fm_stereo_mixer i_fm_stereo_mixer (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ch_word_i   (ch_word),
    .ch_pan_i    (ch_pan),
    .ofs_set_i   (ofs_set),
    .ofs_val_i   (ofs_val),
    .smp_strobe_i(strobe),
    .left_o      (left_s),
    .right_o     (right_s),
    .valid_o     (valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int term(input logic [15:0] w, input bit en, input bit on);
    int v;
    v = int'(w & 16'h3FE0);
    if (w[13]) v = v - 16384;
    if (on) v = (v >= 0) ? v + 112 : v - 112;
    if (en) return on ? (v * 79) / 120 : (v * 2) / 3;
    if (on) return (v >= 0) ? (112 * 79) / 120 : -((112 * 79) / 120);
    return 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: computes expected pair, queues it, pulses the strobe.
  task automatic send(input logic [95:0] w, input logic [11:0] p, input string tag,
                      input bit wr = 1'b0, input bit wval = 1'b0);
    int l = 0, r = 0;
    for (int i = 0; i < 6; i++) begin
      l += term(w[16*i +: 16], p[2*i+1], model_on);
      r += term(w[16*i +: 16], p[2*i], model_on);
    end
    exp_l.push_back(l);
    exp_r.push_back(r);
    exp_tag.push_back(tag);
    @(negedge clk);
    ch_word = w;
    ch_pan  = p;
    strobe  = 1'b1;
    ofs_set = wr;
    ofs_val = wval;
    @(negedge clk);
    strobe  = 1'b0;
    ofs_set = 1'b0;
    if (wr) model_on = wval;
  endtask

  task automatic set_mode(input bit v);
    @(negedge clk);
    ofs_set = 1'b1;
    ofs_val = v;
    @(negedge clk);
    ofs_set = 1'b0;
    model_on = v;
  endtask

  // Monitor: pops and compares whenever a pair is presented.
  always @(negedge clk) begin
    if (rst_n && valid && !done) begin
      if (exp_l.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R8: actual valid=1 expected valid=0 (no pending strobe)");
      end else begin
        string t;
        int el, er;
        t  = exp_tag.pop_front();
        el = exp_l.pop_front();
        er = exp_r.pop_front();
        check({t, " left"},  int'(left_s),  el);
        check({t, " right"}, int'(right_s), er);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    ch_word = '0;
    ch_pan  = '0;
    ofs_set = 1'b0;
    ofs_val = 1'b0;
    strobe  = 1'b0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 reset valid", int'(valid), 0);
    check("R8 reset left", int'(left_s), 0);
    check("R8 reset right", int'(right_s), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6/R2: default offset mode, zero words give pure DC term (+73 each)
    send('0, 12'hFFF, "R6 default mode R2 zero");
    // R4: left only / right only
    send({6{16'h0100}}, 12'hAAA, "R4 left only R5");
    send({6{16'h0100}}, 12'h555, "R4 right only R5");
    // R1: ignored bits set
    send({6{16'hC01F}}, 12'hFFF, "R1 ignored bits");
    // R7: full scale positive and negative, no overflow
    send({6{16'h1FE0}}, 12'hFFF, "R7 full positive");
    send({6{16'h2000}}, 12'hFFF, "R7 full negative R1 sign");
    // R3: truncation toward zero on a small negative
    send({6{16'h3FE0}}, 12'hFFF, "R3 trunc negative");
    // R5: all muted, negative samples give -73 each
    send({6{16'h2000}}, 12'h000, "R5 muted negative");
    // R6: mode value without a write has no effect
    @(negedge clk); ofs_val = 1'b0;
    send({6{16'h0420}}, 12'h9C3, "R6 value without write");
    // R6: write in same cycle as strobe uses old mode
    send({6{16'h0420}}, 12'h9C3, "R6 write with strobe", 1'b1, 1'b0);
    // Plain mode now active
    send({6{16'h0420}}, 12'h9C3, "R3 plain scale R2 no offset");
    send({6{16'h3FE0}}, 12'hFFF, "R3 plain trunc");
    send({6{16'h2000}}, 12'h000, "R5 plain muted zero");
    send({6{16'h1FE0}}, 12'hFFF, "R7 plain full");
    set_mode(1'b1);
    send('0, 12'h000, "R6 mode restored R5");
    // Mixed patterns, back to back
    for (int k = 0; k < 60; k++) begin
      logic [95:0] w;
      for (int c = 0; c < 3; c++) w[32*c +: 32] = $urandom;
      if (k == 30) set_mode(1'b0);
      send(w, 12'($urandom), "R7 random mix");
    end
    repeat (4) @(negedge clk);
    check("R8 pending pairs", exp_l.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule